// File: doc/BRIEF.md
# Associative TLB translation unit

This block translates a virtual address through a small, fully associative table of page entries. Every valid entry is compared at once against the incoming address. The comparison ignores the address bits below the entry's page size. It also checks the entry's process tag against the current process number. The lowest-numbered entry that matches supplies the physical page base, the page size code, its own index and a permission set.

The permission set comes from the entry's write and execute enables. A two-bit zone field, taken from a caller-supplied zone protection word and selected by the entry's zone number, can widen or remove those permissions. The lookup is combinational and completes in the same cycle as its inputs.

The table is loaded one entry per clock through a write port driven by a register-access block. A written entry takes part in lookups from the next cycle on.

Top module: `tlb_lookup`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports miss until an entry is written with its valid bit set.
- R2: An entry with size code n (0..7) covers 1024·4^n bytes. It matches when the address and the entry's virtual tag are equal in all bits at and above bit 10+2n; lower bits are ignored.
- R3: An entry with a nonzero 8-bit process tag matches only when bits [7:0] of `pid` equal that tag. An entry whose process tag is zero matches for every `pid`.
- R4: When several entries match, the entry with the lowest index is used.
- R5: When the result is not miss, `pa` equals the entry's physical page value ANDed with parameter PA_MASK (default 32'h3FFF_FFFF). In that case `pg_size` is the entry's size code and `hit_idx` is the entry's index. On a miss, `pa`, `pg_size`, `hit_idx` and `perm` are all zero.
- R6: `perm` bit 0 is read, bit 1 is write and bit 2 is execute. Entry permissions are read, plus write when the entry's write enable is set, plus execute when its execute enable is set.
- R7: Zone z uses bits [31-2z:30-2z] of `zpr`. Field 00 gives no permissions in user mode (`sup`=0) and entry permissions in supervisor mode. Field 01 gives entry permissions in both modes. Field 10 gives all three permissions in supervisor mode and entry permissions in user mode. Field 11 gives all three permissions in both modes.
- R8: An entry whose zone number exceeds parameter NUM_ZONES (default 12) does not read `zpr`; it is given entry permissions.
- R9: `acc` is 0 for read, 1 for write and 2 for instruction fetch; 3 is treated as read. `res` is 00 on a miss. It is 01 when the matched entry's `perm` holds the bit the access needs, and 10 (protection fault) when it does not. The value 11 never occurs.
- R10: When `wr_en` is high at a clock edge, entry `wr_idx` takes all the `wr_*` fields. The change is seen by lookups from that edge on, and writing `wr_valid`=0 removes the entry from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for entry writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write the entry selected by wr_idx |
| wr_idx | input | 4 | Entry index to write |
| wr_valid | input | 1 | Valid bit for the written entry |
| wr_vtag | input | 32 | Virtual page tag |
| wr_size | input | 3 | Page size code |
| wr_tid | input | 8 | Process tag, zero means global |
| wr_rpn | input | 32 | Physical page value |
| wr_wen | input | 1 | Entry write enable |
| wr_xen | input | 1 | Entry execute enable |
| wr_zone | input | 4 | Zone number |
| va | input | 32 | Address to translate |
| acc | input | 2 | Access type |
| pid | input | 32 | Current process number, low 8 bits used |
| zpr | input | 32 | Zone protection word |
| sup | input | 1 | Supervisor mode |
| res | output | 2 | 00 miss, 01 hit, 10 protection fault |
| pa | output | 32 | Physical page base |
| pg_size | output | 3 | Size code of matched entry |
| hit_idx | output | 4 | Index of matched entry |
| perm | output | 3 | Granted permissions {exec, write, read} |

## Verification
A corrupted entry field shows up in the same cycle as the next lookup that reaches that entry. A wrong tag or size shows as a spurious miss or hit, a wrong process tag as a match for the wrong process, and a wrong enable or zone number as a changed `perm` or an unexpected fault. A lost valid bit, or a write to the wrong index, is exposed from the very next cycle by `hit_idx` and `res` on a lookup aimed at the entry. Random tables built from a few shared page bases produce many overlapping matches, so a priority error shows up as a wrong `hit_idx` within a few lookups.

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
  parameter int ENTRIES = 16,
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int NUM_ZONES = 12,
  parameter logic [PA_W-1:0] PA_MASK = 32'h3FFF_FFFF,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [VA_W-1:0]  wr_vtag,
  input  logic [2:0]       wr_size,
  input  logic [7:0]       wr_tid,
  input  logic [PA_W-1:0]  wr_rpn,
  input  logic             wr_wen,
  input  logic             wr_xen,
  input  logic [3:0]       wr_zone,
  input  logic [VA_W-1:0]  va,
  input  logic [1:0]       acc,
  input  logic [31:0]      pid,
  input  logic [31:0]      zpr,
  input  logic             sup,
  output logic [1:0]       res,
  output logic [PA_W-1:0]  pa,
  output logic [2:0]       pg_size,
  output logic [IDX_W-1:0] hit_idx,
  output logic [2:0]       perm
);

  logic             v_q   [ENTRIES];
  logic [VA_W-1:0]  tag_q [ENTRIES];
  logic [2:0]       sz_q  [ENTRIES];
  logic [7:0]       tid_q [ENTRIES];
  logic [PA_W-1:0]  rpn_q [ENTRIES];
  logic             we_q  [ENTRIES];
  logic             xe_q  [ENTRIES];
  logic [3:0]       zn_q  [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        v_q[i]   <= 1'b0;
        tag_q[i] <= '0;
        sz_q[i]  <= '0;
        tid_q[i] <= '0;
        rpn_q[i] <= '0;
        we_q[i]  <= 1'b0;
        xe_q[i]  <= 1'b0;
        zn_q[i]  <= '0;
      end
    end else if (wr_en) begin
      v_q[wr_idx]   <= wr_valid;
      tag_q[wr_idx] <= wr_vtag;
      sz_q[wr_idx]  <= wr_size;
      tid_q[wr_idx] <= wr_tid;
      rpn_q[wr_idx] <= wr_rpn;
      we_q[wr_idx]  <= wr_wen;
      xe_q[wr_idx]  <= wr_xen;
      zn_q[wr_idx]  <= wr_zone;
    end
  end

  function automatic logic [VA_W-1:0] page_mask(input logic [2:0] s);
    page_mask = ~((VA_W'(1) << (10 + 2 * int'(s))) - VA_W'(1));
  endfunction

  logic [ENTRIES-1:0] m;
  always_comb
    for (int i = 0; i < ENTRIES; i++)
      m[i] = v_q[i] && (((tag_q[i] ^ va) & page_mask(sz_q[i])) == '0) &&
             (tid_q[i] == 8'd0 || tid_q[i] == pid[7:0]);

  logic             any;
  logic [IDX_W-1:0] sel;
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (m[i]) begin
        any = 1'b1;
        sel = IDX_W'(i);
      end
  end

  logic [1:0] zf;
  logic [2:0] p, need;
  always_comb begin
    if (int'(zn_q[sel]) > NUM_ZONES) zf = 2'b01;
    else zf = 2'((zpr >> (30 - 2 * int'(zn_q[sel]))) & 32'd3);
    if (zf == 2'b00 && !sup) p = 3'b000;
    else if (zf == 2'b11 || (zf == 2'b10 && sup)) p = 3'b111;
    else p = {xe_q[sel], we_q[sel], 1'b1};
  end

  assign need    = (acc == 2'd1) ? 3'b010 : (acc == 2'd2) ? 3'b100 : 3'b001;
  assign res     = !any ? 2'b00 : ((p & need) != 3'b000) ? 2'b01 : 2'b10;
  assign pa      = any ? (rpn_q[sel] & PA_MASK) : '0;
  assign pg_size = any ? sz_q[sel] : '0;
  assign hit_idx = any ? sel : '0;
  assign perm    = any ? p : '0;

endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int IDX_W = 4,
  parameter int PA_W = 32,
  parameter logic [PA_W-1:0] PA_MASK = 32'h3FFF_FFFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       acc,
  input logic [1:0]       res,
  input logic [PA_W-1:0]  pa,
  input logic [2:0]       pg_size,
  input logic [IDX_W-1:0] hit_idx,
  input logic [2:0]       perm
);
  logic [2:0] need;
  assign need = (acc == 2'd1) ? 3'b010 : (acc == 2'd2) ? 3'b100 : 3'b001;

  a_r9_res_legal: assert property (@(posedge clk) disable iff (!rst_n)
    res != 2'b11);
  a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res == 2'b00 |-> (pa == '0 && pg_size == 3'd0 && hit_idx == '0 && perm == 3'd0));
  a_r5_pa_masked: assert property (@(posedge clk) disable iff (!rst_n)
    res != 2'b00 |-> (pa & ~PA_MASK) == '0);
  a_r9_hit_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    res == 2'b01 |-> (perm & need) != 3'b000);
  a_r9_fault_denied: assert property (@(posedge clk) disable iff (!rst_n)
    res == 2'b10 |-> (perm & need) == 3'b000);
  a_r6_read_base: assert property (@(posedge clk) disable iff (!rst_n)
    perm != 3'b000 |-> perm[0]);
endmodule

bind tlb_lookup tlb_lookup_chk #(.IDX_W(IDX_W), .PA_W(PA_W), .PA_MASK(PA_MASK)) u_chk (.*);

// File: tb/tlb_lookup_tb.sv
module tlb_lookup_tb;
  localparam int PERIOD = 10;
  localparam int N = 16;
  localparam logic [31:0] PMASK = 32'h3FFF_FFFF;
  localparam int NZ = 12;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_valid = 0, wr_wen = 0, wr_xen = 0, sup = 0;
  logic [3:0] wr_idx = 0, wr_zone = 0;
  logic [31:0] wr_vtag = 0, wr_rpn = 0, va = 0, pid = 0, zpr = 0;
  logic [2:0] wr_size = 0;
  logic [7:0] wr_tid = 0;
  logic [1:0] acc = 0;
  logic [1:0] res;
  logic [31:0] pa;
  logic [2:0] pg_size, perm;
  logic [3:0] hit_idx;

  always #(PERIOD/2) clk = ~clk;

  tlb_lookup u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  logic        mv [N];
  logic [31:0] mtag [N], mrpn [N];
  logic [2:0]  msz [N];
  logic [7:0]  mtid [N];
  logic        mwe [N], mxe [N];
  logic [3:0]  mzn [N];

  task automatic put(input int i, input logic v, input logic [31:0] t, input logic [2:0] s,
                     input logic [7:0] td, input logic [31:0] r, input logic w, input logic x,
                     input logic [3:0] z);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(i); wr_valid = v; wr_vtag = t; wr_size = s; wr_tid = td;
    wr_rpn = r; wr_wen = w; wr_xen = x; wr_zone = z;
    @(negedge clk);
    wr_en = 0;
    mv[i] = v; mtag[i] = t; msz[i] = s; mtid[i] = td; mrpn[i] = r;
    mwe[i] = w; mxe[i] = x; mzn[i] = z;
  endtask

  function automatic logic [13:0] model(input logic [31:0] a, input logic [1:0] ac,
                                        input logic [31:0] pd, input logic [31:0] zp,
                                        input logic sp, output logic [31:0] epa);
    logic [31:0] mk;
    logic [1:0] f;
    logic [2:0] p, nd;
    epa = 0;
    for (int i = 0; i < N; i++) begin
      mk = ~((32'd1 << (10 + 2 * int'(msz[i]))) - 32'd1);
      if (mv[i] && ((mtag[i] & mk) == (a & mk)) && (mtid[i] == 0 || mtid[i] == pd[7:0])) begin
        if (int'(mzn[i]) > NZ) f = 2'b01;
        else f = zp[31 - 2*int'(mzn[i]) -: 2];
        if (f == 2'b00 && !sp) p = 0;
        else if (f == 2'b11 || (f == 2'b10 && sp)) p = 3'b111;
        else p = {mxe[i], mwe[i], 1'b1};
        nd = (ac == 1) ? 3'b010 : (ac == 2) ? 3'b100 : 3'b001;
        epa = mrpn[i] & PMASK;
        return {((p & nd) != 0) ? 2'b01 : 2'b10, msz[i], 4'(i), p, 2'b00};
      end
    end
    return 14'd0;
  endfunction

  task automatic look(input string tag, input logic [31:0] a, input logic [1:0] ac,
                      input logic [31:0] pd, input logic [31:0] zp, input logic sp);
    logic [13:0] e;
    logic [31:0] epa;
    @(negedge clk);
    va = a; acc = ac; pid = pd; zpr = zp; sup = sp;
    #1;
    e = model(a, ac, pd, zp, sp, epa);
    checks++;
    if ({res, pg_size, hit_idx, perm, 2'b00} !== e || pa !== epa) begin
      errors++;
      $display("FAIL %s: res=%b size=%0d idx=%0d perm=%b pa=%h expected res=%b size=%0d idx=%0d perm=%b pa=%h",
               tag, res, pg_size, hit_idx, perm, pa, e[13:12], e[11:9], e[8:5], e[4:2], epa);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [4];
    for (int i = 0; i < N; i++) begin
      mv[i] = 0; mtag[i] = 0; msz[i] = 0; mtid[i] = 0; mrpn[i] = 0;
      mwe[i] = 0; mxe[i] = 0; mzn[i] = 0;
    end
    void'($urandom(1234));
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1: empty table
    look("R1", 32'h0, 0, 0, 32'hFFFF_FFFF, 1);
    look("R1", 32'h1234_5678, 2, 8'h00, 0, 0);
    // R10 and R2: 4 KiB page (code 1), offset bits ignored
    put(3, 1, 32'h4000_1000, 1, 8'd0, 32'hC000_5000, 1, 0, 4'd1);
    look("R10", 32'h4000_1FFF, 0, 0, 32'h1000_0000, 0);
    look("R2", 32'h4000_2000, 0, 0, 32'h1000_0000, 0);
    // R5: pa masked with PA_MASK
    look("R5", 32'h4000_1004, 1, 0, 32'h1000_0000, 0);
    // R9: fetch without execute enable -> fault; acc 3 as read
    look("R9", 32'h4000_1004, 2, 0, 32'h1000_0000, 0);
    look("R9", 32'h4000_1004, 3, 0, 32'h1000_0000, 0);
    // R3: process tag
    put(5, 1, 32'h5000_0000, 7, 8'h2A, 32'h0100_0000, 1, 1, 4'd0);
    look("R3", 32'h50FF_FFFF, 0, 32'hFFFF_FF2A, 32'h4000_0000, 0);
    look("R3", 32'h5000_0000, 0, 32'h0000_002B, 32'h4000_0000, 0);
    // R4: lower index wins over an overlapping entry
    put(2, 1, 32'h5000_0400, 0, 8'd0, 32'h0000_0400, 0, 0, 4'd2);
    look("R4", 32'h5000_0410, 0, 32'h2A, 32'h4400_0000, 0);
    // R7: every zone field in both modes on zone 2 (write access)
    for (int f = 0; f < 4; f++)
      for (int s = 0; s < 2; s++)
        look("R7", 32'h5000_0410, 1, 32'h2A, 32'(f) << 26, s[0]);
    // R8: zone 15 beyond NUM_ZONES ignores zpr
    put(7, 1, 32'h7000_0000, 2, 8'd0, 32'hFFFF_0000, 1, 1, 4'd15);
    look("R8", 32'h7000_0000, 2, 0, 32'h0000_0000, 0);
    put(8, 1, 32'h7100_0000, 2, 8'd0, 32'h1111_0000, 0, 1, 4'd12);
    look("R7", 32'h7100_0000, 0, 0, 32'h0000_0000, 0);
    // R10: invalidate
    put(3, 0, 32'h4000_1000, 1, 8'd0, 32'hC000_5000, 1, 0, 4'd1);
    look("R10", 32'h4000_1000, 0, 0, 32'hFFFF_FFFF, 1);
    // R6 random tables and lookups
    bases[0] = 32'h1000_0000; bases[1] = 32'h1003_0000;
    bases[2] = 32'h2000_0000; bases[3] = $urandom;
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N; i++)
        put(i, ($urandom % 8) != 0, bases[$urandom % 4] ^ ($urandom & 32'h0003_FC00),
            3'($urandom), ($urandom % 3 == 0) ? 8'($urandom % 3) : 8'd0, $urandom,
            1'($urandom), 1'($urandom), 4'($urandom));
      for (int k = 0; k < 300; k++)
        look("R6", bases[$urandom % 4] ^ ($urandom & 32'h000F_FFFF), 2'($urandom),
             $urandom % 3, $urandom, 1'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule